// File: doc/BRIEF.md
# Tagged Schedule Image Extractor

This block sits at one leaf of a broadcast network that carries schedule updates to many nodes. Each token on the network holds a tag that names the node it is meant for, plus a data word. The extractor acknowledges every token so that the broadcast never waits on it. It keeps only the tokens whose tag equals its own node tag. From those tokens it rebuilds this node's slot-table image and writes it into a table memory through a single write port made of address, data and a one-cycle write strobe.

The token interface uses a two-phase toggle handshake. A token is offered by flipping `tok_req`, with `tok_tag` and `tok_data` held stable alongside it. The block accepts the token by flipping `tok_ack` back to the same level. There is no start marker. When the block is idle, the first token carrying its own tag gives the image length. The next that many tokens with its own tag are written to consecutive table addresses from 0 upward. After the last of them the block returns to idle by itself.

The controller has two states. In `ST_IDLE` the index is held at 0 and a matching token loads the length. The transition *idle→extract* is taken when that length is nonzero, and *idle→idle* when it is zero. In `ST_EXTRACT` each matching token writes one entry. The transition *extract→extract* is taken while entries remain, and *extract→idle* when the index reaches the length.

Top module: `sched_extractor`

## Requirements
- R1: A token is pending while `tok_req` differs from `tok_ack`. On the next rising clock edge the block toggles `tok_ack`, which consumes the token. This happens for every token, whatever its tag.
- R2: The controller has only the states `ST_IDLE` and `ST_EXTRACT`. In `ST_IDLE` the write index is 0.
- R3: In `ST_IDLE`, a token whose `tok_tag` equals `own_tag` loads its length from `tok_data[ADDR_W:0]`, the low ADDR_W+1 bits. No write is made for this token. The block enters `ST_EXTRACT` when the length is nonzero.
- R4: In `ST_EXTRACT`, each token whose tag matches produces one write. `wr_data` carries the token's data word and `wr_addr` carries the current index.
- R5: The index rises by one after each write. When it reaches the loaded length, it returns to 0 and the block goes back to `ST_IDLE`, so the next matching token is taken as a new length.
- R6: A token whose tag differs from `own_tag` is acknowledged but causes no write and changes neither the state nor the index.
- R7: A length of 0 leaves the block in `ST_IDLE` without any write.
- R8: For each token that produces a write, `wr_en` is high for exactly one cycle, in the cycle after the edge that consumed the token.
- R9: After reset, `tok_ack` is 0, `wr_en` is 0 and the block is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_tag | input | TAG_W | Tag of this node |
| tok_req | input | 1 | Token request; each toggle offers one token |
| tok_tag | input | TAG_W | Destination tag of the offered token |
| tok_data | input | DATA_W | Data word of the offered token |
| tok_ack | output | 1 | Acknowledge; toggles to consume a token |
| wr_en | output | 1 | One-cycle write strobe for the table memory |
| wr_addr | output | ADDR_W | Table write address |
| wr_data | output | DATA_W | Table write data |

## Verification
The bench builds the block with TAG_W=4, DATA_W=16 and ADDR_W=3. With these values the length field is four bits wide and the largest image, 8 entries, fills the whole address range. That makes the final write at address 7 and the wrap of the index back to 0 reachable within a few dozen tokens. Foreign tags are mixed into images in progress. The bench also sends a zero length, loads two images back to back, and changes `own_tag` during the run, so that one tag is foreign in one phase and matching in the next.

// File: rtl/sched_extractor_pkg.sv
package sched_extractor_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_EXTRACT = 1'b1
    } xstate_t;
endpackage

// File: rtl/sched_tok_accept.sv
module sched_tok_accept (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_req,
    output logic tok_ack,
    output logic tok_new
);
    logic phase_q;

    assign tok_new = (tok_req != phase_q);
    assign tok_ack = phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase_q <= 1'b0;
        else if (tok_new) phase_q <= ~phase_q;
    end

    // R1
    ack_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_new |=> (tok_ack != $past(tok_ack)));
endmodule

// File: rtl/sched_extract_ctrl.sv
module sched_extract_ctrl
    import sched_extractor_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_new,
    input  logic              tag_hit,
    input  logic [DATA_W-1:0] tok_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int SZ_W = ADDR_W + 1;

    xstate_t         state, state_nxt;
    logic [SZ_W-1:0] idx, idx_nxt;
    logic [SZ_W-1:0] len, len_nxt;
    logic            take, do_wr;
    logic [SZ_W-1:0] idx_inc;

    assign take    = tok_new && tag_hit;
    assign idx_inc = idx + 1'b1;

    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        len_nxt   = len;
        do_wr     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idx_nxt = '0;
                if (take) begin
                    len_nxt = tok_data[SZ_W-1:0];
                    if (tok_data[SZ_W-1:0] != '0) state_nxt = ST_EXTRACT;
                end
            end
            ST_EXTRACT: begin
                if (take) begin
                    do_wr = 1'b1;
                    if (idx_inc == len) begin
                        idx_nxt   = '0;
                        state_nxt = ST_IDLE;
                    end else begin
                        idx_nxt = idx_inc;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            len   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
            len   <= len_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= do_wr;
            if (do_wr) begin
                wr_addr <= idx[ADDR_W-1:0];
                wr_data <= tok_data;
            end
        end
    end

    // R2
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (idx == '0));
    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXTRACT) |-> (idx < len));
    // R6
    foreign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_new && !tag_hit) |=> ($stable(state) && $stable(idx) && !wr_en));
endmodule

// File: rtl/sched_extractor.sv
module sched_extractor #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  own_tag,
    input  logic              tok_req,
    input  logic [TAG_W-1:0]  tok_tag,
    input  logic [DATA_W-1:0] tok_data,
    output logic              tok_ack,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic tok_new;
    logic tag_hit;

    assign tag_hit = (tok_tag == own_tag);

    sched_tok_accept u_accept (
        .clk     (clk),
        .rst_n   (rst_n),
        .tok_req (tok_req),
        .tok_ack (tok_ack),
        .tok_new (tok_new)
    );

    sched_extract_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_new  (tok_new),
        .tag_hit  (tag_hit),
        .tok_data (tok_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // R8
    wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(tok_new));
endmodule

// File: tb/tb_sched_extractor.sv
module tb_sched_extractor;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int SZ_W   = ADDR_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TAG_W-1:0]  own_tag = 4'd5;
    logic              tok_req = 1'b0;
    logic [TAG_W-1:0]  tok_tag = '0;
    logic [DATA_W-1:0] tok_data = '0;
    logic              tok_ack;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [ADDR_W+DATA_W-1:0] exp_q[$];

    // requirement model
    bit              m_extract = 1'b0;
    logic [SZ_W-1:0] m_len = '0;
    logic [SZ_W-1:0] m_idx = '0;

    always #4 clk = ~clk;

    sched_extractor #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .own_tag(own_tag),
        .tok_req(tok_req), .tok_tag(tok_tag), .tok_data(tok_data),
        .tok_ack(tok_ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected writes (R4)
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 actual=%0h expected=none", {wr_addr, wr_data});
            end else begin
                logic [ADDR_W+DATA_W-1:0] e;
                e = exp_q.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    fails++;
                    $display("FAIL R4 actual=%0h expected=%0h", {wr_addr, wr_data}, e);
                end
            end
        end
    end

    // driver: models the requirements, then offers one token
    task automatic send(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] data);
        bit will_wr;
        will_wr = 1'b0;
        if (tag == own_tag) begin
            if (!m_extract) begin
                m_len = data[SZ_W-1:0];
                m_idx = '0;
                if (m_len != '0) m_extract = 1'b1;  // R3, R7
            end else begin
                will_wr = 1'b1;
                exp_q.push_back({m_idx[ADDR_W-1:0], data});
                m_idx = m_idx + 1'b1;
                if (m_idx == m_len) begin           // R5
                    m_idx = '0;
                    m_extract = 1'b0;
                end
            end
        end
        tok_tag  = tag;
        tok_data = data;
        tok_req  = ~tok_req;
        @(negedge clk);
        check("R1", {31'd0, tok_ack}, {31'd0, tok_req});
        check(will_wr ? "R8" : "R6", {31'd0, wr_en}, {31'd0, will_wr});
        @(negedge clk);
        check("R8", {31'd0, wr_en}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", {31'd0, tok_ack}, 32'd0);
        check("R9", {31'd0, wr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: foreign token while idle
        send(4'd3, 16'h0004);
        // R3: own length 3, R6 foreign mixed in, R4/R5 writes 0..2
        send(4'd5, 16'h0003);
        send(4'd5, 16'hA000);
        send(4'd9, 16'h0BAD);
        send(4'd5, 16'hA001);
        send(4'd1, 16'h0002);
        send(4'd5, 16'hA002);
        // R5: back in idle, next match is a length
        // R7: zero length, no write
        send(4'd5, 16'hFFF0);
        send(4'd5, 16'h0002);
        send(4'd5, 16'hB000);
        send(4'd5, 16'hB001);
        // R2: full image of 8, addresses 0..7
        send(4'd5, 16'h0008);
        for (int i = 0; i < 8; i++) begin
            send(4'd5, 16'hC000 + 16'(i));
            if (i == 3) send(4'd7, 16'h1234);
        end
        // own tag changes: 5 now foreign, 7 matches
        own_tag = 4'd7;
        send(4'd5, 16'h0001);
        send(4'd7, 16'h0001);
        send(4'd5, 16'hDEAD);
        send(4'd7, 16'hD000);

        repeat (3) @(negedge clk);
        check("R4", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule